// File: doc/BRIEF.md
# Indirect Vector Table Window

This block opens a small window in a 32-bit memory-mapped register space through which a host reaches an on-chip interrupt vector table. The window has two dword registers. One holds data and the other holds a command word. A command word carries a direction bit, a type code, a byte-lane mask and a byte offset. Only the vector table type is served. The host starts a table read by writing a command with the direction bit clear. It then polls the command register until the top bit reads as set, and collects the dword from the data register. For a table write, the host loads the data register first. It then writes a command with the top bit set and polls until that bit reads as clear.

Host accesses arrive on a request channel with valid/ready handshaking. Read results leave on a response channel, also with valid/ready. A response is held stable until it is taken, and no further read is accepted while an untaken response is pending. Writes are stalled while a table command is in flight. The table itself is an external RAM with a one-cycle synchronous read, driven through a plain strobe port.

Top module: `vec_table_window`

## Requirements
- R1: After a synchronous active-low reset, the command register and the data register both read as 0, no table access is in progress and no response is pending.
- R2: The data register sits at window byte address 0x70 and the command register at 0x74. A read of any other address, misaligned addresses included, returns 0. A write to any other address changes nothing.
- R3: A command write whose bits 30:16 equal 0x0001 and whose bit 31 is 0 reads table dword number offset[7:2], where offset is bits 11:0. Once the command completes, the command register reads back the written word with bit 31 set, and the data register returns that table dword.
- R4: A command write whose bits 30:16 equal 0x0001 and whose bit 31 is 1 stores the current data register value into table dword offset[7:2]. Once the command completes, the command register reads back the written word with bit 31 cleared.
- R5: The status bit 31 flips at the second clock edge after the edge that accepts the command write. Reads of the command register accepted at the first and second edges after that edge return the word as written. Each command makes exactly one table access.
- R6: Command bits 15:12 have no effect. Every transfer moves a full dword.
- R7: A table command whose offset bits 11:8 are not all zero (beyond the 64-dword table) reads as 0 and performs no table write. Its status bit still flips.
- R8: A command write whose bits 30:16 differ from 0x0001 is stored and read back unchanged. It makes no table access and leaves the data register untouched, and its bit 31 never flips.
- R9: While no table read has completed since the last data write, the data register returns the last value written to it.
- R10: A response stays valid with unchanged data until rsp_ready is high. A read request is not accepted while an untaken response is pending. A write request is not accepted during the two cycles after a table command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Host request accepted when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Window byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Host takes the response |
| rsp_rdata | output | 32 | Read response data |
| tbl_req | output | 1 | Table access strobe |
| tbl_we | output | 1 | Table access is a write |
| tbl_idx | output | IDX_W | Table dword index |
| tbl_wdata | output | 32 | Table write data |
| tbl_rdata | input | 32 | Table read data, valid the cycle after a read strobe |

## Verification
Table reads are issued at several indices, including the first and the last dword. A mask-laden command shows that bits 15:12 do not change the transfer, and an out-of-range offset shows that decode stops at the table boundary. A write followed by a read at the same index separates the two directions and shows the write data path. Commands with a foreign type code show that the type field gates all table activity. Back-to-back polls accepted at consecutive edges pin the exact edge where the flag flips. A stalled response and a stalled write show that back-pressure neither drops nor duplicates anything.

// File: rtl/vtw_pkg.sv
package vtw_pkg;
  localparam logic [14:0] KIND_VECTAB = 15'h0001;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_DATA = 2'd1,
    SEL_CMD  = 2'd2
  } win_sel_e;

  typedef struct packed {
    logic        go;
    logic [14:0] kind;
    logic [3:0]  lanes;
    logic [11:0] ofs;
  } cmd_word_t;
endpackage

// File: rtl/vtw_decode.sv
module vtw_decode
  import vtw_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] DATA_OFS = 'h70,
  parameter logic [ADDR_W-1:0] CMD_OFS  = 'h74
) (
  input  logic [ADDR_W-1:0] addr,
  output win_sel_e          sel
);
  always_comb begin
    if (addr == DATA_OFS)     sel = SEL_DATA;
    else if (addr == CMD_OFS) sel = SEL_CMD;
    else                      sel = SEL_NONE;
  end
endmodule

// File: rtl/vtw_engine.sv
module vtw_engine
  import vtw_pkg::*;
#(
  parameter int unsigned TBL_DEPTH = 64,
  localparam int unsigned IDX_W = $clog2(TBL_DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic             data_wr,
  input  logic [31:0]      wdata,
  input  logic [31:0]      tbl_rdata,
  output logic [31:0]      cmd_q,
  output logic [31:0]      data_q,
  output logic             busy,
  output logic             tbl_req,
  output logic             tbl_we,
  output logic [IDX_W-1:0] tbl_idx,
  output logic [31:0]      tbl_wdata
);
  cmd_word_t       cw;
  logic            kind_ok, in_range;
  logic            stg_issue, stg_done;
  logic            op_we, op_inr;
  logic [IDX_W-1:0] op_idx;
  logic            unused_bits;

  assign cw          = cmd_word_t'(wdata);
  assign kind_ok     = (cw.kind == KIND_VECTAB);
  assign in_range    = ({22'd0, cw.ofs[11:2]} < TBL_DEPTH);
  assign unused_bits = ^{cw.lanes, cw.ofs[1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q     <= '0;
      data_q    <= '0;
      stg_issue <= 1'b0;
      stg_done  <= 1'b0;
      op_we     <= 1'b0;
      op_inr    <= 1'b0;
      op_idx    <= '0;
    end else begin
      stg_issue <= cmd_wr && kind_ok;
      stg_done  <= stg_issue;
      if (cmd_wr) begin
        cmd_q  <= wdata;
        op_we  <= cw.go;
        op_inr <= in_range;
        op_idx <= cw.ofs[IDX_W+1:2];
      end
      if (data_wr) data_q <= wdata;
      if (stg_done) begin
        cmd_q[31] <= ~cmd_q[31];
        if (!op_we) data_q <= op_inr ? tbl_rdata : 32'd0;
      end
    end
  end

  assign busy      = stg_issue | stg_done;
  assign tbl_req   = stg_issue && op_inr;
  assign tbl_we    = stg_issue && op_inr && op_we;
  assign tbl_idx   = op_idx;
  assign tbl_wdata = data_q;
endmodule

// File: rtl/vtw_resp.sv
module vtw_resp (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [31:0] load_data,
  input  logic        rsp_ready,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (load) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= load_data;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/vec_table_window.sv
module vec_table_window
  import vtw_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] DATA_OFS = 'h70,
  parameter logic [ADDR_W-1:0] CMD_OFS  = 'h74,
  parameter int unsigned TBL_DEPTH = 64,
  localparam int unsigned IDX_W = $clog2(TBL_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_rdata,
  output logic              tbl_req,
  output logic              tbl_we,
  output logic [IDX_W-1:0]  tbl_idx,
  output logic [31:0]       tbl_wdata,
  input  logic [31:0]       tbl_rdata
);
  win_sel_e    sel;
  logic        busy, accept, cmd_wr, data_wr, rd_load;
  logic [31:0] cmd_q, data_q, rd_val;

  vtw_decode #(.ADDR_W(ADDR_W), .DATA_OFS(DATA_OFS), .CMD_OFS(CMD_OFS)) u_dec (
    .addr(req_addr), .sel(sel)
  );

  assign req_ready = req_write ? !busy : (!rsp_valid || rsp_ready);
  assign accept    = req_valid && req_ready;
  assign cmd_wr    = accept && req_write && (sel == SEL_CMD);
  assign data_wr   = accept && req_write && (sel == SEL_DATA);
  assign rd_load   = accept && !req_write;

  always_comb begin
    unique case (sel)
      SEL_DATA: rd_val = data_q;
      SEL_CMD:  rd_val = cmd_q;
      default:  rd_val = 32'd0;
    endcase
  end

  vtw_engine #(.TBL_DEPTH(TBL_DEPTH)) u_eng (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .data_wr(data_wr),
    .wdata(req_wdata), .tbl_rdata(tbl_rdata), .cmd_q(cmd_q), .data_q(data_q),
    .busy(busy), .tbl_req(tbl_req), .tbl_we(tbl_we), .tbl_idx(tbl_idx),
    .tbl_wdata(tbl_wdata)
  );

  vtw_resp u_rsp (
    .clk(clk), .rst_n(rst_n), .load(rd_load), .load_data(rd_val),
    .rsp_ready(rsp_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );
endmodule

// File: rtl/vtw_checker.sv
module vtw_checker #(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CMD_OFS = 'h74
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [31:0]       req_wdata,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [31:0]       rsp_rdata,
  input logic              tbl_req,
  input logic              tbl_we
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> (!tbl_req && !rsp_valid));

  assert_single_access_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_req |=> !tbl_req);

  assert_kind_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_req |-> $past(req_valid && req_ready && req_write && req_addr == CMD_OFS
                      && req_wdata[30:16] == 15'h0001));

  assert_write_dir_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_req |-> (tbl_we == $past(req_wdata[31])));

  assert_write_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_req |-> !(req_valid && req_ready && req_write));

  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));
endmodule

bind vec_table_window vtw_checker #(.ADDR_W(ADDR_W), .CMD_OFS(CMD_OFS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
  .tbl_req(tbl_req), .tbl_we(tbl_we)
);

// File: tb/test_vec_table_window.sv
`timescale 1ns/1ps
module test_vec_table_window;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid, tbl_req, tbl_we;
  logic [31:0] rsp_rdata, tbl_wdata, tbl_rdata;
  logic [5:0]  tbl_idx;
  logic [31:0] mem [64];
  int          checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  vec_table_window i_vec_table_window (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .tbl_req(tbl_req), .tbl_we(tbl_we), .tbl_idx(tbl_idx),
    .tbl_wdata(tbl_wdata), .tbl_rdata(tbl_rdata)
  );

  function automatic logic [31:0] seed(int i);
    return 32'hA500_0000 | (32'(i) * 32'h0001_0203);
  endfunction

  always @(posedge clk) begin
    if (tbl_req) begin
      if (tbl_we) mem[tbl_idx] <= tbl_wdata;
      else        tbl_rdata <= mem[tbl_idx];
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic bus_read(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    req_valid = 1'b0;
    @(negedge clk);
    d = rsp_rdata;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
  endtask

  task automatic t_reset_R1();
    logic [31:0] v;
    @(negedge clk);
    check("R1 tbl_req idle", {31'd0, tbl_req}, 32'd0);
    check("R1 rsp_valid idle", {31'd0, rsp_valid}, 32'd0);
    bus_read(8'h74, v); check("R1 cmd after reset", v, 32'd0);
    bus_read(8'h70, v); check("R1 data after reset", v, 32'd0);
  endtask

  task automatic t_window_R2();
    logic [31:0] v;
    bus_write(8'h70, 32'h1111_0000);
    bus_write(8'h72, 32'hFFFF_FFFF);
    bus_write(8'h78, 32'hEEEE_EEEE);
    bus_write(8'h00, 32'hDDDD_DDDD);
    bus_read(8'h70, v); check("R2 R9 data after stray writes", v, 32'h1111_0000);
    bus_read(8'h74, v); check("R2 cmd after stray writes", v, 32'd0);
    bus_read(8'h78, v); check("R2 unmapped read", v, 32'd0);
    bus_read(8'h71, v); check("R2 misaligned read", v, 32'd0);
  endtask

  task automatic t_read_R3();
    logic [31:0] v;
    bus_write(8'h74, 32'h0001_0014);
    settle();
    bus_read(8'h74, v); check("R3 read flag set", v, 32'h8001_0014);
    bus_read(8'h70, v); check("R3 read data idx5", v, seed(5));
    bus_write(8'h74, 32'h0001_0000);
    settle();
    bus_read(8'h70, v); check("R3 read data idx0", v, seed(0));
  endtask

  task automatic t_mask_R6();
    logic [31:0] v;
    bus_write(8'h74, 32'h0001_A03C);
    settle();
    bus_read(8'h74, v); check("R6 mask cmd flag", v, 32'h8001_A03C);
    bus_read(8'h70, v); check("R6 mask full dword", v, seed(15));
  endtask

  task automatic t_write_R4();
    logic [31:0] v;
    bus_write(8'h70, 32'hCAFE_F00D);
    bus_write(8'h74, 32'h8001_0020);
    settle();
    bus_read(8'h74, v); check("R4 write flag cleared", v, 32'h0001_0020);
    check("R4 table idx8 written", mem[8], 32'hCAFE_F00D);
    bus_write(8'h70, 32'h600D_F00D);
    bus_write(8'h74, 32'h8001_00FC);
    settle();
    bus_write(8'h74, 32'h0001_0020);
    settle();
    bus_read(8'h70, v); check("R4 readback idx8", v, 32'hCAFE_F00D);
    bus_write(8'h74, 32'h0001_00FC);
    settle();
    bus_read(8'h70, v); check("R4 readback last idx63", v, 32'h600D_F00D);
  endtask

  task automatic t_range_R7();
    logic [31:0] v;
    bus_write(8'h70, 32'h0000_7777);
    bus_write(8'h74, 32'h8001_0100);
    settle();
    bus_read(8'h74, v); check("R7 out-of-range write flag", v, 32'h0001_0100);
    check("R7 idx0 untouched", mem[0], seed(0));
    bus_write(8'h74, 32'h0001_0104);
    settle();
    bus_read(8'h74, v); check("R7 out-of-range read flag", v, 32'h8001_0104);
    bus_read(8'h70, v); check("R7 out-of-range read zero", v, 32'd0);
  endtask

  task automatic t_kind_R8();
    logic [31:0] v;
    bus_write(8'h70, 32'h1357_9BDF);
    bus_write(8'h74, 32'h0002_0008);
    settle();
    bus_read(8'h74, v); check("R8 foreign read cmd unchanged", v, 32'h0002_0008);
    bus_read(8'h70, v); check("R8 data not latched", v, 32'h1357_9BDF);
    bus_write(8'h74, 32'h8002_0008);
    settle();
    bus_read(8'h74, v); check("R8 foreign write cmd unchanged", v, 32'h8002_0008);
    check("R8 idx2 untouched", mem[2], seed(2));
  endtask

  task automatic t_data_R9();
    logic [31:0] v;
    bus_write(8'h74, 32'h0001_0004);
    settle();
    bus_read(8'h70, v); check("R9 latched table value", v, seed(1));
    bus_write(8'h70, 32'h2468_ACE0);
    bus_read(8'h70, v); check("R9 last written value", v, 32'h2468_ACE0);
  endtask

  task automatic t_latency_R5();
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h74; req_wdata = 32'h0001_0004;
    @(posedge clk); #1;
    req_write = 1'b0;
    @(posedge clk);
    @(negedge clk); check("R5 poll edge1 old", rsp_rdata, 32'h0001_0004);
    @(posedge clk);
    @(negedge clk); check("R5 poll edge2 old", rsp_rdata, 32'h0001_0004);
    @(posedge clk);
    @(negedge clk); check("R5 poll edge3 new", rsp_rdata, 32'h8001_0004);
    req_valid = 1'b0;
  endtask

  task automatic t_stall_R10();
    logic [31:0] v;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h74; req_wdata = 32'h0001_0008;
    @(posedge clk); #1;
    req_addr = 8'h70; req_wdata = 32'h0000_0099;
    @(negedge clk); check("R10 write stalled c1", {31'd0, req_ready}, 32'd0);
    @(negedge clk); check("R10 write stalled c2", {31'd0, req_ready}, 32'd1 - 32'd1);
    @(negedge clk); check("R10 write resumes", {31'd0, req_ready}, 32'd1);
    @(posedge clk); #1;
    req_valid = 1'b0;
    bus_read(8'h70, v); check("R10 stalled write landed", v, 32'h0000_0099);
    rsp_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 8'h70;
    @(posedge clk); #1;
    req_addr = 8'h74;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R10 rsp held valid", {31'd0, rsp_valid}, 32'd1);
      check("R10 rsp held data", rsp_rdata, 32'h0000_0099);
      check("R10 read blocked", {31'd0, req_ready}, 32'd0);
    end
    rsp_ready = 1'b1;
    @(posedge clk); #1;
    req_valid = 1'b0;
    @(negedge clk); check("R10 second read served", rsp_rdata, 32'h8001_0008);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = seed(i);
    tbl_rdata = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset_R1();
    t_window_R2();
    t_read_R3();
    t_mask_R6();
    t_write_R4();
    t_range_R7();
    t_kind_R8();
    t_data_R9();
    t_latency_R5();
    t_stall_R10();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule